// File: doc/BRIEF.md
# RTC Alarm Compare and Interrupt Flags

This block sits beside the time-keeping counters of a real-time clock. Once per second the update logic pulses an update-complete strobe. On that strobe the block compares the current seconds, minutes and hours against three programmable alarm bytes. A separate periodic tick comes from the rate divider. Each of these events latches an event flag in a flag register. Reading that register returns the flags and clears them.

A small byte-wide register port gives access to the alarm bytes, a control register and the flag register. The current time bytes can be read at their own addresses. Enable bits in the control register gate which flags may raise the summary bit and the active-low interrupt request. The flags themselves always latch, whatever the enables.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the flag register (address 12), the alarm bytes and the control register (address 11) read 0x00, and `irq_no` is high.
- R2: Alarm seconds, minutes and hours are written and read back at addresses 1, 3 and 5, and the control byte at address 11. Addresses 0, 2 and 4 read the current seconds, minutes and hours inputs.
- R3: The alarm flag (flag register bit 5) is set in the cycle after an `upd_done_i` pulse during which all three fields match. It is not set if any field differs, and it is not set without an update pulse.
- R4: An alarm byte whose bits 7 and 6 are both 1 matches any current value of its field.
- R5: The periodic flag (bit 6) is set in the cycle after `per_tick_i`. The update-ended flag (bit 4) is set in the cycle after `upd_done_i`.
- R6: The event flags set even when their enables are clear.
- R7: Control bits 6, 5 and 4 enable the periodic, alarm and update-ended flags. Flag register bit 7 is 1 exactly when some flag is set and its enable is set, and `irq_no` is low exactly then.
- R8: A read of address 12 returns the flags and clears all of them in the next cycle.
- R9: If an event arrives in the same cycle as a read of address 12, that read returns the old flags, and the event's flag is set after the read.
- R10: Bits 3 to 0 of the flag register always read 0. Writes to address 12 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe (clears flags at address 12) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from address |
| upd_done_i | input | 1 | One-cycle update-complete strobe |
| per_tick_i | input | 1 | One-cycle periodic event |
| cur_sec_i | input | 8 | Current seconds |
| cur_min_i | input | 8 | Current minutes |
| cur_hr_i | input | 8 | Current hours |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The assertions check the following on every cycle:
- flags are cleared after a read that carries no event;
- an event's flag is set after any event, including one that coincides with a read;
- the alarm flag never rises without an update strobe;
- all-wildcard alarm bytes always match;
- a low request always has a flag behind it;
- the low nibble of the flag register is zero;
- the control register holds what was written.

Only the bench scenarios can show the rest:
- the exact byte returned by a read, before and after clearing;
- that a single mismatching field suppresses the alarm;
- that the flags latch while their enables are off;
- that writes to the flag register are ignored;
- that an event coinciding with a read shows up on the following read.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned ADDR_SEC   = 0;
  localparam int unsigned ADDR_MIN   = 2;
  localparam int unsigned ADDR_HR    = 4;
  localparam int unsigned ADDR_CTRL  = 11;
  localparam int unsigned ADDR_FLAGS = 12;
  localparam int unsigned NUM_ALM    = 3;
  localparam int unsigned NUM_EVT    = 3;

  // event index order matches flag/enable bit order, high to low
  localparam int unsigned EVT_PER = 2;
  localparam int unsigned EVT_ALM = 1;
  localparam int unsigned EVT_UPD = 0;

  // alarm byte of field i sits just above its time byte
  function automatic int unsigned alm_addr(input int unsigned i);
    return 2 * i + 1;
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_irq_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [NUM_ALM-1:0][DW-1:0] alm_o,
  output logic [DW-1:0]              ctrl_o
);
  logic [DW-1:0] ctrl_q;

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_alm
    logic [DW-1:0] alm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alm_q <= '0;
      else if (we_i && addr_i == AW'(alm_addr(i))) alm_q <= wdata_i;
    end
    assign alm_o[i] = alm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && addr_i == AW'(ADDR_CTRL)) ctrl_q <= wdata_i;
  end
  assign ctrl_o = ctrl_q;

  assert_ctrl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(ADDR_CTRL)) |=> (ctrl_o == $past(wdata_i)));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_ALM-1:0][DW-1:0] alm_i,
  input  logic [NUM_ALM-1:0][DW-1:0] cur_i,
  output logic                       match_o
);
  logic [NUM_ALM-1:0] hit;
  logic [NUM_ALM-1:0] wild;

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_fld
    assign wild[i] = &alm_i[i][DW-1:DW-2];
    assign hit[i]  = wild[i] || (alm_i[i] == cur_i[i]);
  end

  assign match_o = &hit;

  assert_wildcard_hits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&{alm_i[0][DW-1:DW-2], alm_i[1][DW-1:DW-2], alm_i[2][DW-1:DW-2]}) |-> match_o);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic               clr_i,
  input  logic [NUM_EVT-1:0] en_i,
  output logic [NUM_EVT-1:0] flags_o,
  output logic               req_o
);
  logic [NUM_EVT-1:0] flag_q;

  // a coincident event survives the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (clr_i ? '0 : flag_q) | set_i;
  end

  assign flags_o = flag_q;
  assign req_o   = |(flag_q & en_i);

  assert_clear_on_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (flag_q == '0));

  assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          upd_done_i,
  input  logic          per_tick_i,
  input  logic [DW-1:0] cur_sec_i,
  input  logic [DW-1:0] cur_min_i,
  input  logic [DW-1:0] cur_hr_i,
  output logic          irq_no
);
  localparam int unsigned EN_LSB = DW - 1 - NUM_EVT;

  logic [NUM_ALM-1:0][DW-1:0] alm;
  logic [NUM_ALM-1:0][DW-1:0] cur;
  logic [DW-1:0]              ctrl;
  logic                       match;
  logic [NUM_EVT-1:0]         evt_set;
  logic [NUM_EVT-1:0]         flags;
  logic                       req;
  logic                       clr;
  logic [DW-1:0]              flag_byte;

  assign cur = {cur_hr_i, cur_min_i, cur_sec_i};

  rtc_alarm_regs #(.AW(AW), .DW(DW)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .alm_o   (alm),
    .ctrl_o  (ctrl)
  );

  rtc_alarm_match #(.DW(DW)) i_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alm_i   (alm),
    .cur_i   (cur),
    .match_o (match)
  );

  assign evt_set[EVT_PER] = per_tick_i;
  assign evt_set[EVT_ALM] = upd_done_i && match;
  assign evt_set[EVT_UPD] = upd_done_i;
  assign clr = bus_re_i && (bus_addr_i == AW'(ADDR_FLAGS));

  rtc_irq_flags i_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_set),
    .clr_i   (clr),
    .en_i    (ctrl[DW-2:EN_LSB]),
    .flags_o (flags),
    .req_o   (req)
  );

  assign flag_byte = {req, flags, {EN_LSB{1'b0}}};
  assign irq_no    = !req;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      AW'(ADDR_SEC):    bus_rdata_o = cur_sec_i;
      AW'(alm_addr(0)): bus_rdata_o = alm[0];
      AW'(ADDR_MIN):    bus_rdata_o = cur_min_i;
      AW'(alm_addr(1)): bus_rdata_o = alm[1];
      AW'(ADDR_HR):     bus_rdata_o = cur_hr_i;
      AW'(alm_addr(2)): bus_rdata_o = alm[2];
      AW'(ADDR_CTRL):   bus_rdata_o = ctrl;
      AW'(ADDR_FLAGS):  bus_rdata_o = flag_byte;
      default:          bus_rdata_o = '0;
    endcase
  end

  assert_alarm_needs_update_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[EVT_ALM]) |-> $past(upd_done_i));

  assert_irq_needs_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (flags != '0));

  assert_flag_low_nibble_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == AW'(ADDR_FLAGS)) |-> (bus_rdata_o[EN_LSB-1:0] == '0));
endmodule

// File: tb/test_rtc_alarm_irq.sv
module test_rtc_alarm_irq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] bus_addr_i = '0;
  logic       bus_we_i = 1'b0;
  logic       bus_re_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       upd_done_i = 1'b0;
  logic       per_tick_i = 1'b0;
  logic [7:0] cur_sec_i = '0;
  logic [7:0] cur_min_i = '0;
  logic [7:0] cur_hr_i = '0;
  logic       irq_no;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  rtc_alarm_irq i_rtc_alarm_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
    .bus_re_i(bus_re_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .upd_done_i(upd_done_i), .per_tick_i(per_tick_i), .cur_sec_i(cur_sec_i),
    .cur_min_i(cur_min_i), .cur_hr_i(cur_hr_i), .irq_no(irq_no)
  );

  // monitor: compare each read against the scoreboard head
  always @(negedge clk_i) begin
    if (bus_re_i) begin
      rd_item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read: actual=%02h expected=none", bus_rdata_o);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata_o !== it.exp) begin
          failures++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, bus_rdata_o, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(posedge clk_i); #1;
    bus_we_i = 1'b0;
  endtask

  // read, optionally with a coincident periodic or update event
  task automatic rd_evt(input logic [3:0] a, input logic [7:0] e, input string tag,
                        input logic tick, input logic upd);
    rd_item_t it;
    @(posedge clk_i); #1;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_addr_i = a; bus_re_i = 1'b1; per_tick_i = tick; upd_done_i = upd;
    @(posedge clk_i); #1;
    bus_re_i = 1'b0; per_tick_i = 1'b0; upd_done_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    rd_evt(a, e, tag, 1'b0, 1'b0);
  endtask

  task automatic pulse_upd();
    @(posedge clk_i); #1; upd_done_i = 1'b1;
    @(posedge clk_i); #1; upd_done_i = 1'b0;
  endtask

  task automatic pulse_tick();
    @(posedge clk_i); #1; per_tick_i = 1'b1;
    @(posedge clk_i); #1; per_tick_i = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk_i);
    checks++;
    if (irq_no !== e) begin
      failures++;
      $display("FAIL %s irq_no: actual=%0b expected=%0b", tag, irq_no, e);
    end
  endtask

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk_irq(1'b1, "R1");
    rd(4'd12, 8'h00, "R1 flags");
    rd(4'd1,  8'h00, "R1 alarm sec");
    rd(4'd3,  8'h00, "R1 alarm min");
    rd(4'd5,  8'h00, "R1 alarm hr");
    rd(4'd11, 8'h00, "R1 ctrl");

    // R2 register access
    wr(4'd1, 8'h30); wr(4'd3, 8'h15); wr(4'd5, 8'h08); wr(4'd11, 8'h0A);
    rd(4'd1,  8'h30, "R2 alarm sec");
    rd(4'd3,  8'h15, "R2 alarm min");
    rd(4'd5,  8'h08, "R2 alarm hr");
    rd(4'd11, 8'h0A, "R2 ctrl");
    wr(4'd11, 8'h00);
    cur_sec_i = 8'h30; cur_min_i = 8'h15; cur_hr_i = 8'h08;
    rd(4'd0, 8'h30, "R2 cur sec");
    rd(4'd2, 8'h15, "R2 cur min");
    rd(4'd4, 8'h08, "R2 cur hr");

    // R3 R5 R6 match with enables off
    pulse_upd();
    chk_irq(1'b1, "R6 no enable");
    rd(4'd12, 8'h30, "R3 R6 alarm+update flags");
    rd(4'd12, 8'h00, "R8 cleared");

    // R3 no update pulse -> no alarm
    repeat (3) @(posedge clk_i);
    rd(4'd12, 8'h00, "R3 no strobe");

    // R3 one field off
    cur_sec_i = 8'h31;
    pulse_upd();
    rd(4'd12, 8'h10, "R3 mismatch");

    // R4 wildcards
    wr(4'd1, 8'hC0);
    pulse_upd();
    rd(4'd12, 8'h30, "R4 sec wildcard");
    wr(4'd3, 8'hC5); wr(4'd5, 8'hFF);
    cur_min_i = 8'h59; cur_hr_i = 8'h23;
    pulse_upd();
    rd(4'd12, 8'h30, "R4 all wildcard");

    // R5 periodic
    pulse_tick();
    rd(4'd12, 8'h40, "R5 periodic");

    // R7 enable gating
    wr(4'd11, 8'h40);
    pulse_tick();
    chk_irq(1'b0, "R7 periodic enabled");
    rd(4'd12, 8'hC0, "R7 summary");
    chk_irq(1'b1, "R8 irq released");
    wr(4'd11, 8'h20);
    pulse_tick();
    chk_irq(1'b1, "R7 other enable");
    rd(4'd12, 8'h40, "R7 no summary");
    wr(4'd11, 8'h10); wr(4'd1, 8'h00);
    pulse_upd();
    chk_irq(1'b0, "R7 update enabled");
    rd(4'd12, 8'h90, "R7 update summary");

    // R10 write ignored, low nibble zero
    wr(4'd12, 8'hFF);
    rd(4'd12, 8'h00, "R10 write ignored");
    pulse_tick();
    rd(4'd12, 8'h40, "R10 low nibble");

    // R9 event during read
    pulse_tick();
    rd_evt(4'd12, 8'h40, "R9 read with tick", 1'b1, 1'b0);
    rd(4'd12, 8'h40, "R9 tick kept");
    rd(4'd12, 8'h00, "R9 cleared");
    rd_evt(4'd12, 8'h00, "R9 read with update", 1'b0, 1'b1);
    rd(4'd12, 8'h90, "R9 update kept");

    repeat (2) @(posedge clk_i);
    finish_run();
  end
endmodule